// File: doc/BRIEF.md
# Way-Predicting Two-Way Read Cache

This block is a two-way set-associative read cache that answers each lookup speculatively. Every stored line keeps its full tag, and the two lowest tag bits also act as a hint. When a request is accepted, both ways of the addressed set are read. The way whose stored hint matches the hint bits of the request is forwarded at once on the early data port. The full tag compare of both ways runs in the same cycle. Its verdict is registered and appears one cycle later: either a confirm, or a squash that withdraws the early data.

After a squash, the block either hands over the line from the other way on the next cycle, or fetches the line from memory. A fetched line is written into a victim way chosen by a per-set LRU bit and a rule that keeps the hints in a set distinct while a way is still free. The block then delivers the fetched word on the same corrected-data strobe. Only one request is in flight at a time. The consumer treats early data as tentative until confirm arrives, and takes the corrected strobe after a squash.

Top module: `wp_cache`

## Requirements
- R1: While `rst` is high, and in the cycle after it falls, `req_ready` is 1 and `early_valid`, `confirm`, `squash`, `fix_valid` and `mem_req_valid` are 0. Every line is invalid after reset, so the first lookup of any address misses.
- R2: A request is taken only in a cycle where both `req_valid` and `req_ready` are 1. `req_ready` stays 0 from acceptance until the request has finished. A `req_valid` raised while `req_ready` is 0 is ignored and does not disturb the request in progress.
- R3: The address splits into the set index (its low IDX_W bits) and the tag (the remaining upper bits). The hint is tag bits [1:0]. In the cycle after acceptance, `early_valid` is 1 for exactly one cycle. `early_data` is then the word of the lowest-numbered valid way whose stored hint equals the request hint, or of way 0 when no valid way matches.
- R4: In the cycle after `early_valid`, exactly one of `confirm` and `squash` is 1. `confirm` is 1 only when the way chosen by the hint holds a valid line with the full request tag.
- R5: When the unchosen way holds the full-tag hit, `squash` is followed on the next cycle by `fix_valid` with that way's word, and no memory request is made. A confirmed lookup produces neither `fix_valid` nor a memory request.
- R6: On a miss in both ways, the cycle after `squash` raises `mem_req_valid` with `mem_req_addr` equal to the request address. Both stay steady until `mem_rsp_valid` is 1. The next cycle shows `fix_valid` with `fix_data` equal to the returned word, and the line hits on later lookups.
- R7: Victim choice for a fill: with no valid way, way 0. With one valid way, the free way, unless the valid way's hint equals the new hint, in which case the valid way is overwritten. With both ways valid, the LRU way, even if the hints then coincide.
- R8: Each set keeps one LRU bit. A full-tag hit or a fill in a way makes the other way the LRU way of that set.
- R9: At most one of `early_valid`, `confirm`, `squash`, `fix_valid` and `mem_req_valid` is 1 in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Lookup request present |
| req_addr | input | ADDR_W | Word address of the lookup |
| req_ready | output | 1 | Block can take a request this cycle |
| early_valid | output | 1 | Speculative word is on `early_data` |
| early_data | output | DATA_W | Word from the hint-chosen way |
| confirm | output | 1 | Early word was correct |
| squash | output | 1 | Early word must be discarded |
| fix_valid | output | 1 | Corrected word is on `fix_data` |
| fix_data | output | DATA_W | Word from the other way or from memory |
| mem_req_valid | output | 1 | Line fetch request to memory |
| mem_req_addr | output | ADDR_W | Address of the line to fetch |
| mem_rsp_valid | input | 1 | Memory returns the requested word |
| mem_rsp_data | input | DATA_W | Word returned by memory |

## Verification
The bound checker checks the following on every cycle: the spacing of early data, verdict and corrected strobe; the exclusiveness of the verdict and strobes; the fetch request holding steady; a fill's word reaching `fix_data`; and the rule that a busy block ignores requests. What only the bench's scenarios can show is which way the hint picks, whether a verdict is the right one, and where a fill lands. That covers victim selection with duplicate hints, LRU ordering after hits and fills, and a warm reset emptying the cache. All of these show up as expected early words and as the hit, swap or miss outcome of later lookups.

// File: rtl/wpc_pkg.sv
package wpc_pkg;
  localparam int NWAY  = 2;
  localparam int WAY_W = 1;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LOOK,
    ST_JUDGE,
    ST_MISS,
    ST_FIX
  } wpc_state_e;

  typedef enum logic [1:0] {
    VD_CONFIRM,
    VD_SWAP,
    VD_MISS
  } wpc_verdict_e;
endpackage

// File: rtl/wpc_way_ram.sv
module wpc_way_ram #(
  parameter int IDX_W  = 4,
  parameter int TAG_W  = 8,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rd_en,
  input  logic [IDX_W-1:0]  rd_idx,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [TAG_W-1:0]  wr_tag,
  input  logic [DATA_W-1:0] wr_data,
  output logic [TAG_W-1:0]  rd_tag,
  output logic [DATA_W-1:0] rd_data
);
  localparam int DEPTH = 1 << IDX_W;
  localparam int ROW_W = TAG_W + DATA_W;

  logic [ROW_W-1:0] mem [DEPTH];
  logic [ROW_W-1:0] q;

  // single write port, single registered read port
  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_idx] <= {wr_tag, wr_data};
    if (rd_en) q <= mem[rd_idx];
  end

  assign rd_tag  = q[ROW_W-1:DATA_W];
  assign rd_data = q[DATA_W-1:0];
endmodule

// File: rtl/wpc_lookup.sv
module wpc_lookup
  import wpc_pkg::*;
#(
  parameter int TAG_W  = 8,
  parameter int HINT_W = 2
) (
  input  logic [NWAY-1:0]            line_vld,
  input  logic [NWAY-1:0][TAG_W-1:0] line_tag,
  input  logic [TAG_W-1:0]           req_tag,
  output logic [WAY_W-1:0]           hint_way,
  output logic [NWAY-1:0]            tag_hit
);
  logic [NWAY-1:0] hint_hit;

  generate
    for (genvar w = 0; w < NWAY; w++) begin : g_cmp
      assign hint_hit[w] = line_vld[w] && (line_tag[w][HINT_W-1:0] == req_tag[HINT_W-1:0]);
      assign tag_hit[w]  = line_vld[w] && (line_tag[w] == req_tag);
    end
  endgenerate

  // lowest matching way wins, way 0 when none matches
  always_comb begin
    hint_way = '0;
    for (int w = NWAY - 1; w >= 0; w--) begin
      if (hint_hit[w]) hint_way = WAY_W'(w);
    end
  end
endmodule

// File: rtl/wpc_victim.sv
module wpc_victim
  import wpc_pkg::*;
#(
  parameter int HINT_W = 2
) (
  input  logic [NWAY-1:0]             line_vld,
  input  logic [NWAY-1:0][HINT_W-1:0] line_hint,
  input  logic [HINT_W-1:0]           new_hint,
  input  logic [WAY_W-1:0]            lru_way,
  output logic [WAY_W-1:0]            victim
);
  always_comb begin
    case (line_vld)
      2'b00:   victim = 1'b0;
      2'b01:   victim = (line_hint[0] == new_hint) ? 1'b0 : 1'b1;
      2'b10:   victim = (line_hint[1] == new_hint) ? 1'b1 : 1'b0;
      default: victim = lru_way;
    endcase
  end
endmodule

// File: rtl/wp_cache.sv
module wp_cache
  import wpc_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int IDX_W  = 4,
  parameter int DATA_W = 16,
  parameter int HINT_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  output logic              req_ready,
  output logic              early_valid,
  output logic [DATA_W-1:0] early_data,
  output logic              confirm,
  output logic              squash,
  output logic              fix_valid,
  output logic [DATA_W-1:0] fix_data,
  output logic              mem_req_valid,
  output logic [ADDR_W-1:0] mem_req_addr,
  input  logic              mem_rsp_valid,
  input  logic [DATA_W-1:0] mem_rsp_data
);
  localparam int TAG_W = ADDR_W - IDX_W;
  localparam int SETS  = 1 << IDX_W;

  wpc_state_e   st;
  wpc_verdict_e verdict, verdict_q;

  logic [ADDR_W-1:0] req_q;
  logic [IDX_W-1:0]  cur_idx;
  logic [TAG_W-1:0]  cur_tag;
  logic              accept;
  logic              fill_en;

  logic [NWAY-1:0]             vld [SETS];
  logic [SETS-1:0]             lru;
  logic [NWAY-1:0][TAG_W-1:0]  rtag;
  logic [NWAY-1:0][DATA_W-1:0] rdata;
  logic [NWAY-1:0][HINT_W-1:0] rhint;
  logic [NWAY-1:0]             tag_hit;
  logic [WAY_W-1:0]            hint_way, other_way, hit_way, victim;
  logic                        confirm_q, squash_q;
  logic [DATA_W-1:0]           fix_q;

  assign cur_idx = req_q[IDX_W-1:0];
  assign cur_tag = req_q[ADDR_W-1:IDX_W];
  assign accept  = req_valid && (st == ST_IDLE);
  assign fill_en = (st == ST_MISS) && mem_rsp_valid;

  generate
    for (genvar w = 0; w < NWAY; w++) begin : g_way
      wpc_way_ram #(
        .IDX_W (IDX_W),
        .TAG_W (TAG_W),
        .DATA_W(DATA_W)
      ) u_ram (
        .clk    (clk),
        .rd_en  (accept),
        .rd_idx (req_addr[IDX_W-1:0]),
        .wr_en  (fill_en && (victim == WAY_W'(w))),
        .wr_idx (cur_idx),
        .wr_tag (cur_tag),
        .wr_data(mem_rsp_data),
        .rd_tag (rtag[w]),
        .rd_data(rdata[w])
      );
      assign rhint[w] = rtag[w][HINT_W-1:0];
    end
  endgenerate

  wpc_lookup #(
    .TAG_W (TAG_W),
    .HINT_W(HINT_W)
  ) u_lookup (
    .line_vld(vld[cur_idx]),
    .line_tag(rtag),
    .req_tag (cur_tag),
    .hint_way(hint_way),
    .tag_hit (tag_hit)
  );

  wpc_victim #(
    .HINT_W(HINT_W)
  ) u_victim (
    .line_vld (vld[cur_idx]),
    .line_hint(rhint),
    .new_hint (cur_tag[HINT_W-1:0]),
    .lru_way  (lru[cur_idx]),
    .victim   (victim)
  );

  assign other_way = ~hint_way;
  assign hit_way   = tag_hit[1] ? 1'b1 : 1'b0;

  always_comb begin
    if (tag_hit[hint_way])       verdict = VD_CONFIRM;
    else if (tag_hit[other_way]) verdict = VD_SWAP;
    else                         verdict = VD_MISS;
  end

  // control state, valid bits, LRU bits
  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= ST_IDLE;
      confirm_q <= 1'b0;
      squash_q  <= 1'b0;
      verdict_q <= VD_CONFIRM;
      lru       <= '0;
      for (int s = 0; s < SETS; s++) vld[s] <= '0;
    end else begin
      confirm_q <= 1'b0;
      squash_q  <= 1'b0;
      case (st)
        ST_IDLE: if (req_valid) st <= ST_LOOK;
        ST_LOOK: begin
          confirm_q <= (verdict == VD_CONFIRM);
          squash_q  <= (verdict != VD_CONFIRM);
          verdict_q <= verdict;
          if (verdict != VD_MISS) lru[cur_idx] <= ~hit_way;
          st <= ST_JUDGE;
        end
        ST_JUDGE: begin
          case (verdict_q)
            VD_CONFIRM: st <= ST_IDLE;
            VD_SWAP:    st <= ST_FIX;
            default:    st <= ST_MISS;
          endcase
        end
        ST_MISS: begin
          if (mem_rsp_valid) begin
            vld[cur_idx][victim] <= 1'b1;
            lru[cur_idx]         <= ~victim;
            st                   <= ST_FIX;
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  // datapath registers, no reset needed
  always_ff @(posedge clk) begin
    if (accept) req_q <= req_addr;
    if (st == ST_LOOK) fix_q <= rdata[other_way];
    else if (fill_en)  fix_q <= mem_rsp_data;
  end

  assign req_ready     = (st == ST_IDLE);
  assign early_valid   = (st == ST_LOOK);
  assign early_data    = rdata[hint_way];
  assign confirm       = confirm_q;
  assign squash        = squash_q;
  assign fix_valid     = (st == ST_FIX);
  assign fix_data      = fix_q;
  assign mem_req_valid = (st == ST_MISS);
  assign mem_req_addr  = req_q;
endmodule

// File: rtl/wp_cache_chk.sv
module wp_cache_chk #(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              req_valid,
  input logic              req_ready,
  input logic              early_valid,
  input logic              confirm,
  input logic              squash,
  input logic              fix_valid,
  input logic [DATA_W-1:0] fix_data,
  input logic              mem_req_valid,
  input logic [ADDR_W-1:0] mem_req_addr,
  input logic              mem_rsp_valid,
  input logic [DATA_W-1:0] mem_rsp_data
);
  p_reset_r1: assert property (@(posedge clk)
    rst |=> (req_ready && !early_valid && !confirm && !squash && !fix_valid && !mem_req_valid));

  p_busy_r2: assert property (@(posedge clk) disable iff (rst)
    early_valid |-> !req_ready);

  p_ignore_r2: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !req_ready) |=> !early_valid);

  p_accept_r3: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready) |=> early_valid);

  p_early_once_r3: assert property (@(posedge clk) disable iff (rst)
    early_valid |=> !early_valid);

  p_verdict_r4: assert property (@(posedge clk) disable iff (rst)
    early_valid |=> (confirm != squash));

  p_confirm_quiet_r5: assert property (@(posedge clk) disable iff (rst)
    confirm |=> (!fix_valid && !mem_req_valid));

  p_fix_cause_r5: assert property (@(posedge clk) disable iff (rst)
    fix_valid |-> $past(squash || (mem_req_valid && mem_rsp_valid)));

  p_fetch_hold_r6: assert property (@(posedge clk) disable iff (rst)
    (mem_req_valid && !mem_rsp_valid) |=> (mem_req_valid && $stable(mem_req_addr)));

  p_fill_word_r6: assert property (@(posedge clk) disable iff (rst)
    (mem_req_valid && mem_rsp_valid) |=> (fix_valid && fix_data == $past(mem_rsp_data)));

  p_exclusive_r9: assert property (@(posedge clk) disable iff (rst)
    $onehot0({early_valid, confirm, squash, fix_valid, mem_req_valid}));
endmodule

bind wp_cache wp_cache_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (.*);

// File: tb/sim_wp_cache.sv
module sim_wp_cache;
  localparam int ADDR_W = 12;
  localparam int DATA_W = 16;
  localparam int NVEC   = 23;
  localparam int K_CONF = 0;
  localparam int K_SWAP = 1;
  localparam int K_MISS = 2;

  // {check early word, outcome, address whose word is expected early, request address}
  localparam logic [26:0] VEC [NVEC] = '{
    {1'b0, 2'd2, 12'h000, 12'h013},  // cold set: fill way 0 (R7)
    {1'b1, 2'd0, 12'h013, 12'h013},
    {1'b1, 2'd2, 12'h013, 12'h023},  // no hint match, way 0 early (R3); fill free way 1 (R7)
    {1'b1, 2'd0, 12'h023, 12'h023},
    {1'b1, 2'd0, 12'h013, 12'h013},  // LRU now way 1 (R8)
    {1'b1, 2'd2, 12'h023, 12'h063},  // hint picks way 1, both valid: LRU way 1 replaced (R7)
    {1'b1, 2'd2, 12'h063, 12'h023},  // LRU way 0 replaced, hints now equal (R7)
    {1'b1, 2'd1, 12'h023, 12'h063},  // lowest hint match way 0, hit in way 1 (R5)
    {1'b1, 2'd0, 12'h023, 12'h023},
    {1'b0, 2'd2, 12'h000, 12'h015},
    {1'b1, 2'd2, 12'h015, 12'h055},  // same hint as valid way 0: overwrite it (R7)
    {1'b1, 2'd0, 12'h055, 12'h055},
    {1'b1, 2'd2, 12'h055, 12'h015},  // proves 015 was evicted (R7)
    {1'b1, 2'd2, 12'h015, 12'h025},  // different hint: free way 1 (R7)
    {1'b1, 2'd0, 12'h015, 12'h015},
    {1'b1, 2'd0, 12'h025, 12'h025},
    {1'b0, 2'd2, 12'h000, 12'h017},
    {1'b1, 2'd2, 12'h017, 12'h027},
    {1'b1, 2'd2, 12'h017, 12'h037},  // both valid, LRU way 0 replaced (R8)
    {1'b1, 2'd0, 12'h027, 12'h027},
    {1'b1, 2'd0, 12'h037, 12'h037},  // hit way 0 makes way 1 LRU (R8)
    {1'b1, 2'd2, 12'h037, 12'h017},  // way 1 replaced (R8)
    {1'b1, 2'd2, 12'h037, 12'h027}   // way 0 replaced after the fill (R8)
  };

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              req_valid = 1'b0;
  logic [ADDR_W-1:0] req_addr = '0;
  logic              req_ready;
  logic              early_valid;
  logic [DATA_W-1:0] early_data;
  logic              confirm;
  logic              squash;
  logic              fix_valid;
  logic [DATA_W-1:0] fix_data;
  logic              mem_req_valid;
  logic [ADDR_W-1:0] mem_req_addr;
  logic              mem_rsp_valid = 1'b0;
  logic [DATA_W-1:0] mem_rsp_data = '0;

  int total = 0;
  int bad   = 0;
  int cyc   = 0;
  bit done  = 1'b0;

  always #2 clk = ~clk;

  wp_cache u0 (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_addr(req_addr),
    .req_ready(req_ready), .early_valid(early_valid), .early_data(early_data),
    .confirm(confirm), .squash(squash), .fix_valid(fix_valid), .fix_data(fix_data),
    .mem_req_valid(mem_req_valid), .mem_req_addr(mem_req_addr),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data)
  );

  function automatic logic [DATA_W-1:0] word_of(input logic [ADDR_W-1:0] a);
    return {a[3:0], a} ^ 16'h5A3C;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic access(input logic [ADDR_W-1:0] a, input int kind, input bit chk_e,
                        input logic [ADDR_W-1:0] ea, input int delay, input bit poke);
    @(negedge clk);
    chk(req_ready == 1'b1, "R2 ready before request", 32'(req_ready), 1);
    req_valid = 1'b1;
    req_addr  = a;
    @(negedge clk);                       // lookup cycle
    req_valid = 1'b0;
    chk(early_valid == 1'b1, "R3 early_valid", 32'(early_valid), 1);
    chk(req_ready == 1'b0, "R2 busy during lookup", 32'(req_ready), 0);
    if (chk_e) chk(early_data == word_of(ea), "R3 early_data", 32'(early_data), 32'(word_of(ea)));
    @(negedge clk);                       // verdict cycle
    chk(early_valid == 1'b0 && fix_valid == 1'b0, "R9 strobes quiet at verdict",
        32'({early_valid, fix_valid}), 0);
    if (kind == K_CONF)
      chk(confirm && !squash, "R4 confirm", 32'({confirm, squash}), 32'b10);
    else
      chk(!confirm && squash, "R4 squash", 32'({confirm, squash}), 32'b01);
    @(negedge clk);
    if (kind == K_CONF) begin
      chk(!fix_valid && !mem_req_valid && req_ready, "R5 confirmed lookup ends quietly",
          32'({fix_valid, mem_req_valid, req_ready}), 32'b001);
    end else if (kind == K_SWAP) begin
      chk(fix_valid && !mem_req_valid, "R5 swap strobe", 32'({fix_valid, mem_req_valid}), 32'b10);
      chk(fix_data == word_of(a), "R5 swap word", 32'(fix_data), 32'(word_of(a)));
    end else begin
      chk(mem_req_valid && mem_req_addr == a, "R6 fetch address",
          32'({mem_req_valid, mem_req_addr}), 32'({1'b1, a}));
      for (int d = 0; d < delay; d++) begin
        if (poke) begin
          req_valid = 1'b1;
          req_addr  = 12'h099;
        end
        @(negedge clk);
        req_valid = 1'b0;
        chk(mem_req_valid && mem_req_addr == a, "R6 fetch held",
            32'({mem_req_valid, mem_req_addr}), 32'({1'b1, a}));
        chk(!early_valid, "R2 busy request ignored", 32'(early_valid), 0);
      end
      mem_rsp_valid = 1'b1;
      mem_rsp_data  = word_of(a);
      @(negedge clk);
      mem_rsp_valid = 1'b0;
      mem_rsp_data  = '0;
      chk(fix_valid && fix_data == word_of(a), "R6 fill word",
          32'({fix_valid, fix_data}), 32'({1'b1, word_of(a)}));
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000 && !done) begin
      done = 1'b1;
      total++;
      bad++;
      $display("FAIL watchdog actual=%0d expected<=%0d", cyc, 20000);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(req_ready && !early_valid && !confirm && !squash && !fix_valid && !mem_req_valid,
        "R1 reset outputs", 32'({req_ready, early_valid, confirm, squash, fix_valid, mem_req_valid}),
        32'b100000);
    rst = 1'b0;
    @(negedge clk);
    chk(req_ready && !early_valid && !mem_req_valid, "R1 after reset",
        32'({req_ready, early_valid, mem_req_valid}), 32'b100);

    for (int i = 0; i < NVEC; i++) begin
      access(VEC[i][11:0], int'(VEC[i][25:24]), VEC[i][26], VEC[i][23:12], i % 3, 1'b0);
    end

    // R2: requests raised while a fetch is pending are ignored
    access(12'h01A, K_MISS, 1'b0, 12'h000, 3, 1'b1);
    @(negedge clk);
    chk(!early_valid && req_ready, "R2 no stray lookup after busy request",
        32'({early_valid, req_ready}), 32'b01);
    access(12'h01A, K_CONF, 1'b1, 12'h01A, 0, 1'b0);

    // R1: warm reset empties the cache
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    access(12'h023, K_MISS, 1'b0, 12'h000, 1, 1'b0);  // R1 line lost after reset
    access(12'h023, K_CONF, 1'b1, 12'h023, 0, 1'b0);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule